// File: doc/BRIEF.md
# Cache-Line Access Combining Selector

This combinational block looks at the entries of a load-store queue, listed in logical order from the head, and chooses which of them may be carried out together as one access to a single cache line. Each entry carries a valid bit, its line address, an operation-type code, a fence flag, a write flag and a byte mask within the line. The block picks a head entry from the top row of the queue and broadcasts that entry's line address. Every other entry compares its own line address against the broadcast address. The block then works out which later entries may join the head's access.

Joining follows the queue order. It is cut off by any valid entry that acts as a fence or that has a different operation type. It is also refused when bytes would overlap an earlier entry on the same line and either of the two accesses writes. The block finds the cut-off point, accumulates the byte masks and counts the grants with parallel prefix scans over associative operators (OR and saturating add), so the logic depth grows with the logarithm of the queue depth rather than linearly. The output is a grant vector with one bit per queue slot. At most four bits are set by default, the head's bit is always one of them, and a valid flag and the broadcast address come with it.

Top module: `combineSelector`

## Requirements
- R1: The head is the lowest-numbered valid entry among logical positions 0 to ROW-1. When such an entry exists, `bcastValid` is 1 and `bcastAddr` equals that entry's line address.
- R2: When no entry in positions 0 to ROW-1 is valid, `bcastValid` is 0, `grant` is all zeros and `bcastAddr` is 0, whatever the lower rows hold.
- R3: When `bcastValid` is 1, the head's bit in `grant` is set, even if no other entry can join it.
- R4: A non-head entry is granted only if it is valid, its line address equals `bcastAddr` and its operation-type code equals the head's code. A valid entry on another line with the same code does not prevent later entries from joining.
- R5: A valid entry placed after the head that has its fence flag set, or whose operation code differs from the head's, prevents every entry after it from being granted.
- R6: An entry with its fence flag set is granted only as the head. When the head is a fence, the head is the only entry granted.
- R7: A candidate is refused if its byte mask overlaps the mask of an earlier valid write on the same line, or if the candidate is itself a write and overlaps any earlier valid entry on the same line. The earlier entry counts whether or not it was granted, and overlapping reads may both be granted.
- R8: At most MAXG entries are granted (default 4). When more entries are eligible, the MAXG lowest-positioned eligible entries are granted, the head included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| entryValid | input | N | Entry holds an operation, bit i is logical position i |
| entryAddr | input | N*AW | Cache-line address of each entry, entry i at bits [i*AW +: AW] |
| entryOp | input | N*OW | Operation-type code of each entry, entry i at bits [i*OW +: OW] |
| entryFence | input | N | Entry behaves as an ordering fence |
| entryWrite | input | N | Entry writes memory |
| entryMask | input | N*MB | Byte mask within the line, entry i at bits [i*MB +: MB] |
| grant | output | N | Entries chosen for this combined access |
| bcastAddr | output | AW | Line address of the head entry, 0 when there is none |
| bcastValid | output | 1 | A head entry was found this cycle |

## Verification
The block holds no state, so any wrong internal value shows up in the same cycle as a wrong grant bit or a wrong broadcast address. If the head choice is wrong, the address, the head's grant bit and the base for the type comparison all move together. If a prefix scan is broken, either a grant appears after a fence, a type change or a byte overlap, or a grant goes missing or is added at the four-grant limit. Directed vectors cover each cut-off rule on its own, and a long sweep of small-address random queues with frequent line collisions is compared against a serial walk written directly from the rules.

// File: rtl/combineSelectorPkg.sv
package combineSelectorPkg;

  // Operator applied at each node of a prefix scan.
  typedef enum logic [0:0] {
    SCAN_OR     = 1'b0,
    SCAN_SATADD = 1'b1
  } scanKindE;

  // Strobes passed from the control path to the datapath.
  typedef struct packed {
    logic headFound;
  } headStrobeT;

endpackage

// File: rtl/prefixScan.sv
module prefixScan
  import combineSelectorPkg::*;
#(
  parameter int       N    = 16,
  parameter int       W    = 1,
  parameter scanKindE KIND = SCAN_OR,
  parameter int       CAP  = 4
) (
  input  logic [N*W-1:0] inVec,
  output logic [N*W-1:0] inclusive,
  output logic [N*W-1:0] exclusive
);

  localparam int LEVELS = (N > 1) ? $clog2(N) : 1;

  function automatic logic [W-1:0] combineOp(input logic [W-1:0] lhs, input logic [W-1:0] rhs);
    logic [W:0] sum;
    if (KIND == SCAN_OR) begin
      combineOp = lhs | rhs;
    end else begin
      sum = {1'b0, lhs} + {1'b0, rhs};
      combineOp = (sum > (W+1)'(CAP)) ? W'(CAP) : sum[W-1:0];
    end
  endfunction

  // Kogge-Stone network: level l combines each element with the one 2**l below it.
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int DIST = 1 << l;
    logic [N*W-1:0] prevV;
    logic [N*W-1:0] outV;

    if (l == 0) begin : g_first
      assign prevV = inVec;
    end else begin : g_next
      assign prevV = g_lvl[l-1].outV;
    end

    always_comb begin
      for (int i = 0; i < N; i++) begin
        if (i >= DIST) begin
          outV[i*W +: W] = combineOp(prevV[(i-DIST)*W +: W], prevV[i*W +: W]);
        end else begin
          outV[i*W +: W] = prevV[i*W +: W];
        end
      end
    end
  end

  assign inclusive = g_lvl[LEVELS-1].outV;
  assign exclusive = {inclusive[(N-1)*W-1:0], {W{1'b0}}};

endmodule

// File: rtl/combineDatapath.sv
module combineDatapath
  import combineSelectorPkg::*;
#(
  parameter int N   = 16,
  parameter int ROW = 4,
  parameter int AW  = 26,
  parameter int OW  = 2,
  parameter int MB  = 8
) (
  input  logic [N-1:0]    entryValid,
  input  logic [N*AW-1:0] entryAddr,
  input  logic [N*OW-1:0] entryOp,
  input  logic [N-1:0]    entryWrite,
  input  logic [N*MB-1:0] entryMask,
  input  logic [N-1:0]    headOneHot,
  input  headStrobeT      headStb,
  output logic [AW-1:0]   bcastAddr,
  output logic [N-1:0]    sameLine,
  output logic [N-1:0]    opDiffer,
  output logic [N-1:0]    overlapBlock
);

  logic [OW-1:0]   headOp;
  logic [N*MB-1:0] writeMaskIn;
  logic [N*MB-1:0] anyMaskIn;
  logic [N*MB-1:0] writeMaskIncl;
  logic [N*MB-1:0] anyMaskIncl;
  logic [N*MB-1:0] writeMaskBefore;
  logic [N*MB-1:0] anyMaskBefore;

  // AND-OR mux of the head's fields; only top-row slots can be the head.
  always_comb begin
    bcastAddr = '0;
    headOp    = '0;
    for (int i = 0; i < ROW; i++) begin
      bcastAddr = bcastAddr | ({AW{headOneHot[i]}} & entryAddr[i*AW +: AW]);
      headOp    = headOp    | ({OW{headOneHot[i]}} & entryOp[i*OW +: OW]);
    end
  end

  // Broadcast comparison and per-entry mask contributions.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      sameLine[i] = headStb.headFound && (entryAddr[i*AW +: AW] == bcastAddr);
      opDiffer[i] = (entryOp[i*OW +: OW] != headOp);
      anyMaskIn[i*MB +: MB]   = (entryValid[i] && sameLine[i]) ? entryMask[i*MB +: MB] : '0;
      writeMaskIn[i*MB +: MB] = (entryValid[i] && sameLine[i] && entryWrite[i])
                                ? entryMask[i*MB +: MB] : '0;
    end
  end

  prefixScan #(.N(N), .W(MB), .KIND(SCAN_OR), .CAP(0)) u_writeScan (
    .inVec    (writeMaskIn),
    .inclusive(writeMaskIncl),
    .exclusive(writeMaskBefore)
  );

  prefixScan #(.N(N), .W(MB), .KIND(SCAN_OR), .CAP(0)) u_anyScan (
    .inVec    (anyMaskIn),
    .inclusive(anyMaskIncl),
    .exclusive(anyMaskBefore)
  );

  // Conflict: touching an earlier write, or writing over any earlier access.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      overlapBlock[i] = (|(entryMask[i*MB +: MB] & writeMaskBefore[i*MB +: MB])) ||
                        (entryWrite[i] && (|(entryMask[i*MB +: MB] & anyMaskBefore[i*MB +: MB])));
    end
  end

  // Inclusive results are consumed only through the exclusive form.
  logic unusedIncl;
  assign unusedIncl = ^{writeMaskIncl, anyMaskIncl};

endmodule

// File: rtl/combineControl.sv
module combineControl
  import combineSelectorPkg::*;
#(
  parameter int N    = 16,
  parameter int ROW  = 4,
  parameter int MAXG = 4
) (
  input  logic [N-1:0] entryValid,
  input  logic [N-1:0] entryFence,
  input  logic [N-1:0] sameLine,
  input  logic [N-1:0] opDiffer,
  input  logic [N-1:0] overlapBlock,
  output logic [N-1:0] headOneHot,
  output headStrobeT   headStb,
  output logic [N-1:0] grant,
  output logic         bcastValid
);

  localparam int CW = $clog2(MAXG + 1);

  logic [ROW-1:0]  topValid;
  logic [ROW-1:0]  topFirst;
  logic [N-1:0]    breaker;
  logic [N-1:0]    breakIncl;
  logic [N-1:0]    brokenBefore;
  logic [N-1:0]    eligible;
  logic [N*CW-1:0] eligCountIn;
  logic [N*CW-1:0] eligCountIncl;
  logic [N*CW-1:0] eligCountBefore;

  // Head: lowest valid slot of the top row (isolate lowest set bit).
  assign topValid = entryValid[ROW-1:0];
  assign topFirst = topValid & (~topValid + ROW'(1));

  if (N > ROW) begin : g_headPad
    assign headOneHot = {{(N-ROW){1'b0}}, topFirst};
  end else begin : g_headNoPad
    assign headOneHot = topFirst;
  end

  assign headStb.headFound = |topValid;
  assign bcastValid        = headStb.headFound;

  // Slots before the head are empty, so a plain prefix OR gives the cut-off.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      breaker[i] = entryValid[i] && (entryFence[i] || opDiffer[i]);
    end
  end

  prefixScan #(.N(N), .W(1), .KIND(SCAN_OR), .CAP(0)) u_breakScan (
    .inVec    (breaker),
    .inclusive(breakIncl),
    .exclusive(brokenBefore)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      eligible[i] = headOneHot[i] ||
                    (headStb.headFound && entryValid[i] && !entryFence[i] && !opDiffer[i] &&
                     sameLine[i] && !overlapBlock[i] && !brokenBefore[i]);
      eligCountIn[i*CW +: CW] = CW'(eligible[i]);
    end
  end

  prefixScan #(.N(N), .W(CW), .KIND(SCAN_SATADD), .CAP(MAXG)) u_countScan (
    .inVec    (eligCountIn),
    .inclusive(eligCountIncl),
    .exclusive(eligCountBefore)
  );

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant[i] = eligible[i] && (eligCountBefore[i*CW +: CW] < CW'(MAXG));
    end
  end

  logic unusedIncl;
  assign unusedIncl = ^{breakIncl, eligCountIncl};

endmodule

// File: rtl/combineSelector.sv
module combineSelector
  import combineSelectorPkg::*;
#(
  parameter int N    = 16,
  parameter int ROW  = 4,
  parameter int AW   = 26,
  parameter int OW   = 2,
  parameter int MB   = 8,
  parameter int MAXG = 4
) (
  input  logic [N-1:0]    entryValid,
  input  logic [N*AW-1:0] entryAddr,
  input  logic [N*OW-1:0] entryOp,
  input  logic [N-1:0]    entryFence,
  input  logic [N-1:0]    entryWrite,
  input  logic [N*MB-1:0] entryMask,
  output logic [N-1:0]    grant,
  output logic [AW-1:0]   bcastAddr,
  output logic            bcastValid
);

  logic [N-1:0] headOneHot;
  headStrobeT   headStb;
  logic [N-1:0] sameLine;
  logic [N-1:0] opDiffer;
  logic [N-1:0] overlapBlock;

  combineControl #(.N(N), .ROW(ROW), .MAXG(MAXG)) u_ctl (
    .entryValid  (entryValid),
    .entryFence  (entryFence),
    .sameLine    (sameLine),
    .opDiffer    (opDiffer),
    .overlapBlock(overlapBlock),
    .headOneHot  (headOneHot),
    .headStb     (headStb),
    .grant       (grant),
    .bcastValid  (bcastValid)
  );

  combineDatapath #(.N(N), .ROW(ROW), .AW(AW), .OW(OW), .MB(MB)) u_dp (
    .entryValid  (entryValid),
    .entryAddr   (entryAddr),
    .entryOp     (entryOp),
    .entryWrite  (entryWrite),
    .entryMask   (entryMask),
    .headOneHot  (headOneHot),
    .headStb     (headStb),
    .bcastAddr   (bcastAddr),
    .sameLine    (sameLine),
    .opDiffer    (opDiffer),
    .overlapBlock(overlapBlock)
  );

endmodule

// File: rtl/combineSelectorChk.sv
module combineSelectorChk #(
  parameter int N    = 16,
  parameter int ROW  = 4,
  parameter int AW   = 26,
  parameter int MAXG = 4
) (
  input logic [N-1:0]    entryValid,
  input logic [N*AW-1:0] entryAddr,
  input logic [N-1:0]    entryFence,
  input logic [N-1:0]    grant,
  input logic [AW-1:0]   bcastAddr,
  input logic            bcastValid
);

  always_comb begin
    int lowest;
    lowest = N;
    for (int i = N - 1; i >= 0; i--) begin
      if (grant[i]) lowest = i;
    end

    if (!bcastValid) begin
      a_r2_idle_quiet: assert (grant == '0 && bcastAddr == '0)
        else $error("R2: idle selector drives grant or address");
    end

    a_r3_head_exists: assert (bcastValid == (|entryValid[ROW-1:0]))
      else $error("R3: valid flag disagrees with top-row occupancy");

    if (bcastValid) begin
      a_r3_head_granted: assert (lowest < ROW)
        else $error("R3: no top-row grant while a head exists");
      if (lowest < ROW) begin
        a_r1_head_first: assert (entryValid[lowest] && (entryValid & ((N'(1) << lowest) - N'(1))) == '0
                                 && entryAddr[lowest*AW +: AW] == bcastAddr)
          else $error("R1: first grant is not the first valid top-row entry");
      end
    end

    a_r8_grant_cap: assert ($countones(grant) <= MAXG)
      else $error("R8: too many grants");

    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        a_r4_valid_same_line: assert (entryValid[i] && entryAddr[i*AW +: AW] == bcastAddr)
          else $error("R4: granted entry %0d invalid or on another line", i);
        if (entryFence[i]) begin
          a_r6_fence_alone: assert (i == lowest && $countones(grant) == 1)
            else $error("R6: fence entry %0d granted with others", i);
        end
      end
    end
  end

endmodule

bind combineSelector combineSelectorChk #(.N(N), .ROW(ROW), .AW(AW), .MAXG(MAXG)) u_chk (
  .entryValid(entryValid),
  .entryAddr (entryAddr),
  .entryFence(entryFence),
  .grant     (grant),
  .bcastAddr (bcastAddr),
  .bcastValid(bcastValid)
);

// File: tb/combineSelector_bench.sv
module combineSelector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int ROW  = 4;
  localparam int AW   = 2;
  localparam int OW   = 2;
  localparam int MB   = 4;
  localparam int MAXG = 4;
  localparam int RANDOM_VECTORS = 30000;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          vV [N];
  logic [AW-1:0] vA [N];
  logic [OW-1:0] vO [N];
  logic          vF [N];
  logic          vW [N];
  logic [MB-1:0] vM [N];

  logic [N-1:0]    entryValid;
  logic [N*AW-1:0] entryAddr;
  logic [N*OW-1:0] entryOp;
  logic [N-1:0]    entryFence;
  logic [N-1:0]    entryWrite;
  logic [N*MB-1:0] entryMask;
  logic [N-1:0]    grant;
  logic [AW-1:0]   bcastAddr;
  logic            bcastValid;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      entryValid[i]         = vV[i];
      entryAddr[i*AW +: AW] = vA[i];
      entryOp[i*OW +: OW]   = vO[i];
      entryFence[i]         = vF[i];
      entryWrite[i]         = vW[i];
      entryMask[i*MB +: MB] = vM[i];
    end
  end

  combineSelector #(.N(N), .ROW(ROW), .AW(AW), .OW(OW), .MB(MB), .MAXG(MAXG)) u_combineSelector (
    .entryValid(entryValid),
    .entryAddr (entryAddr),
    .entryOp   (entryOp),
    .entryFence(entryFence),
    .entryWrite(entryWrite),
    .entryMask (entryMask),
    .grant     (grant),
    .bcastAddr (bcastAddr),
    .bcastValid(bcastValid)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic clearAll();
    for (int i = 0; i < N; i++) begin
      vV[i] = 0; vA[i] = '0; vO[i] = '0; vF[i] = 0; vW[i] = 0; vM[i] = '0;
    end
  endtask

  task automatic setEntry(input int i, input logic [AW-1:0] a, input logic [OW-1:0] o,
                          input logic f, input logic w, input logic [MB-1:0] m);
    vV[i] = 1; vA[i] = a; vO[i] = o; vF[i] = f; vW[i] = w; vM[i] = m;
  endtask

  // Serial walk over the queue, written from the requirements.
  task automatic refModel(output logic [N-1:0] g, output logic [AW-1:0] a, output logic ok);
    int h;
    int cnt;
    logic broken;
    logic [MB-1:0] wAcc;
    logic [MB-1:0] aAcc;
    logic stopper;
    logic elig;
    h = -1;
    g = '0; a = '0; ok = 0;
    for (int i = ROW - 1; i >= 0; i--) if (vV[i]) h = i;
    if (h >= 0) begin
      ok = 1; a = vA[h];
      g[h] = 1; cnt = 1;
      broken = vF[h];
      aAcc = vM[h];
      wAcc = vW[h] ? vM[h] : '0;
      for (int j = h + 1; j < N; j++) begin
        if (vV[j]) begin
          stopper = vF[j] || (vO[j] != vO[h]);
          elig = !broken && !stopper && (vA[j] == a) &&
                 ((vM[j] & wAcc) == '0) && !(vW[j] && ((vM[j] & aAcc) != '0)) && (cnt < MAXG);
          if (elig) begin g[j] = 1; cnt++; end
          if (vA[j] == a) begin
            aAcc |= vM[j];
            if (vW[j]) wAcc |= vM[j];
          end
          if (stopper) broken = 1;
        end
      end
    end
  endtask

  task automatic checkOut(input string req, input logic [N-1:0] expG,
                          input logic [AW-1:0] expA, input logic expV);
    @(negedge clk);
    checks++;
    if (grant !== expG || bcastAddr !== expA || bcastValid !== expV) begin
      failures++;
      $display("FAIL %s: grant=%b addr=%0d valid=%b expected grant=%b addr=%0d valid=%b",
               req, grant, bcastAddr, bcastValid, expG, expA, expV);
    end
    @(posedge clk);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG_CYCLES) begin
        failures++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected at most %0d", cycles, WATCHDOG_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0]  rg;
    logic [AW-1:0] ra;
    logic          rv;
    clearAll();
    @(posedge clk);

    // R2: empty queue is the idle state.
    checkOut("R2 empty queue", 8'h00, 2'd0, 1'b0);

    // R1: head is the first valid top-row slot (slot 2); slot 5 joins.
    clearAll();
    setEntry(2, 2'd1, 2'd0, 0, 0, 4'b0001);
    setEntry(5, 2'd1, 2'd0, 0, 0, 4'b0010);
    setEntry(6, 2'd3, 2'd0, 0, 0, 4'b0100);
    checkOut("R1 head at slot 2", 8'h24, 2'd1, 1'b1);

    // R2: lower rows full but top row empty.
    clearAll();
    for (int i = ROW; i < N; i++) setEntry(i, 2'd2, 2'd0, 0, 0, 4'b0001 << (i % 4));
    checkOut("R2 top row empty", 8'h00, 2'd0, 1'b0);

    // R5: type change at slot 1 cuts off slots 2 and 3.
    clearAll();
    for (int i = 0; i < 4; i++) setEntry(i, 2'd1, 2'd0, 0, 0, 4'b0001 << i);
    vO[1] = 2'd1;
    checkOut("R5 type change", 8'h01, 2'd1, 1'b1);

    // R4: other-line entry at slot 1 is skipped but does not cut off.
    vO[1] = 2'd0; vA[1] = 2'd2;
    checkOut("R4 other line skipped", 8'h0D, 2'd1, 1'b1);

    // R6: fence head is granted alone.
    clearAll();
    for (int i = 0; i < 4; i++) setEntry(i, 2'd3, 2'd0, 0, 0, 4'b0001 << i);
    vF[0] = 1;
    checkOut("R6 fence head", 8'h01, 2'd3, 1'b1);

    // R6/R5: fence at slot 2 is not granted and blocks slot 3.
    vF[0] = 0; vF[2] = 1;
    checkOut("R6 fence after head", 8'h03, 2'd3, 1'b1);

    // R7: read after an overlapping write is refused.
    clearAll();
    setEntry(0, 2'd0, 2'd0, 0, 1, 4'b0001);
    setEntry(1, 2'd0, 2'd0, 0, 0, 4'b0001);
    setEntry(2, 2'd0, 2'd0, 0, 0, 4'b0010);
    setEntry(3, 2'd0, 2'd0, 0, 0, 4'b0001);
    checkOut("R7 read over write", 8'h05, 2'd0, 1'b1);

    // R7: overlapping reads all combine.
    vW[0] = 0;
    checkOut("R7 overlapping reads", 8'h0F, 2'd0, 1'b1);

    // R7: write over an earlier read is refused; disjoint write joins.
    clearAll();
    setEntry(0, 2'd2, 2'd1, 0, 0, 4'b0001);
    setEntry(1, 2'd2, 2'd1, 0, 1, 4'b0001);
    setEntry(2, 2'd2, 2'd1, 0, 1, 4'b0010);
    checkOut("R7 write over read", 8'h05, 2'd2, 1'b1);

    // R8: eight eligible reads, only the first four granted.
    clearAll();
    for (int i = 0; i < N; i++) setEntry(i, 2'd1, 2'd2, 0, 0, 4'b1111);
    checkOut("R8 grant cap", 8'h0F, 2'd1, 1'b1);

    // R3: head with no partners is still granted.
    clearAll();
    setEntry(0, 2'd1, 2'd0, 0, 1, 4'b1111);
    for (int i = 1; i < N; i++) setEntry(i, 2'd2, 2'd0, 0, 0, 4'b0001);
    checkOut("R3 lone head", 8'h01, 2'd1, 1'b1);

    // Sweep of random queues against the serial walk (R1 to R8).
    for (int t = 0; t < RANDOM_VECTORS; t++) begin
      for (int i = 0; i < N; i++) begin
        vV[i] = ($urandom % 4) != 0;
        vA[i] = AW'($urandom % 4);
        vO[i] = (($urandom % 6) == 0) ? 2'd1 : 2'd0;
        vF[i] = ($urandom % 10) == 0;
        vW[i] = ($urandom % 3) == 0;
        vM[i] = MB'($urandom);
      end
      refModel(rg, ra, rv);
      checkOut("random R1 R3 R4 R5 R6 R7 R8", rg, ra, rv);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule